// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the command front end of a parallel-mode NOR flash with a small behavioural byte array behind it. A host drives an 11-bit multiplexed address, an 8-bit data bus and three active-low strobes: write enable, output enable and a row/column strobe. The row part of the address is taken when the strobe falls and the column part when it rises. Write cycles are decoded as guarded unlock sequences. Four cycles start a byte program. Six cycles start a sector, block or whole-array erase. Any cycle that breaks a sequence drops the decoder back to read mode.

An accepted command starts an internal operation that holds a busy timer. While that operation runs, the block ignores every write. Reads return a polling status byte in place of array data: the complement of the written bit 7, and a bit 6 that flips on each read. Programming can only clear bits. Erase sets a sector, a block or the whole array to all ones, one byte per clock. A low level on the bus reset pin cancels a partly entered sequence and any running operation. All host pins are sampled on the system clock, so every strobe must stay at one level for at least two clocks.

Top module: `flash_cmd_seq`

## Requirements
- R1: After `rst` the data bus is released (`dq_oe`=0), `dq_o` is 0x00, no operation runs and the decoder waits for the first unlock cycle.
- R2: The byte address is {row, column}. The row is the low ROW_W pins sampled when `rc_n` falls. The column is all COL_W pins sampled when `rc_n` rises.
- R3: Byte program is the write-enable-rising cycles AAh@555h, 55h@2AAh, A0h@555h, then data@target. These are the 16-bit unlock addresses 5555h/2AAAh cut to the 11-bit array. The stored byte becomes old AND data, and the operation stays busy PROG_CYC clocks.
- R4: Sector erase is AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h at any address. It sets the aligned 2^SECT_AW-byte sector holding that address to FFh and stays busy 2^SECT_AW clocks.
- R5: The same prefix ending in 50h erases the aligned 2^BLK_AW-byte block (8 blocks by default) and stays busy 2^BLK_AW clocks.
- R6: The same prefix ending in 10h erases the whole array only when the last cycle is at 555h, and stays busy 2^(ROW_W+COL_W) clocks. 10h at any other address does nothing.
- R7: A cycle whose data or address does not fit the sequence returns the decoder to its idle state. A new sequence must then start again with AAh@555h.
- R8: Write cycles during an internal operation have no effect on the array or on the decoder.
- R9: A read during an operation returns bit 7 as the complement of the programmed data bit 7 (0 for erase). Bit 6 is 0 on the first read after the start and flips on every later read. Bits 5..0 are 0.
- R10: `dq_oe` equals NOT `oe_n` as sampled two clocks earlier. On each falling edge of `oe_n`, `dq_o` loads the array byte at the current address, or the status byte when busy.
- R11: `pin_rst_n` low cancels a partly entered sequence and a running operation. Afterwards reads return array data, and an aborted program leaves its byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all host pins are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| pin_rst_n | input | 1 | Bus reset pin, active low |
| we_n | input | 1 | Write enable, active low; data taken on its rising edge |
| oe_n | input | 1 | Output enable, active low |
| rc_n | input | 1 | Row/column strobe: row on falling edge, column on rising edge |
| adr | input | COL_W | Multiplexed address pins |
| dq_i | input | 8 | Data from the host |
| dq_o | output | 8 | Data or status toward the host |
| dq_oe | output | 1 | High while the block drives the data bus |

## Verification
The bench targets the sequence guards. It sends a wrong unlock address, a wrong command byte, and a chip-erase command at a non-unlock address. A decoder that skipped the guards would program or erase the array anyway. It then issues a full erase sequence while a program is running. A design that did not lock out writes would wipe bytes that must keep their value. The bench also checks byte boundaries: the bytes on both sides of a sector or block edge, and a row-only address alias. A wrong mask or a swapped address half would then show up as a wrong byte. It also checks the toggle and complement bits on successive polls, the AND effect of a second program on the same byte, and a bus reset pulse in the middle of a program or a sequence. A block that ignored the pin would write the aborted byte.

// File: rtl/flcs_pkg.sv
`timescale 1ns/1ps
package flcs_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PGM, SQ_ERS, SQ_ERS1, SQ_ERS2
  } seq_t;

  typedef enum logic [1:0] {OP_PROG, OP_SECT, OP_BLK, OP_CHIP} op_t;

  localparam logic [7:0]  K_KEY_A = 8'hAA;
  localparam logic [7:0]  K_KEY_B = 8'h55;
  localparam logic [7:0]  K_PROG  = 8'hA0;
  localparam logic [7:0]  K_ERASE = 8'h80;
  localparam logic [7:0]  K_SECT  = 8'h30;
  localparam logic [7:0]  K_BLK   = 8'h50;
  localparam logic [7:0]  K_CHIP  = 8'h10;
  localparam logic [15:0] KEY_ADR_A = 16'h5555;
  localparam logic [15:0] KEY_ADR_B = 16'h2AAA;
endpackage

// File: rtl/flcs_bus_sampler.sv
`timescale 1ns/1ps
module flcs_bus_sampler #(
  parameter int ROW_W = 4,
  parameter int COL_W = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pin_rst_n,
  input  logic                   we_n,
  input  logic                   oe_n,
  input  logic                   rc_n,
  input  logic [COL_W-1:0]       adr,
  input  logic [7:0]             dq_i,
  output logic                   bus_rst,
  output logic                   wr_stb,
  output logic                   rd_stb,
  output logic                   rd_act,
  output logic [ROW_W+COL_W-1:0] cur_addr,
  output logic [7:0]             wr_data
);
  logic we_q, we_p, oe_q, oe_p, rc_q, rc_p, brst_q;
  logic [COL_W-1:0] adr_q, col_q;
  logic [ROW_W-1:0] row_q;
  logic [7:0]       dq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q <= 1'b1; we_p <= 1'b1;
      oe_q <= 1'b1; oe_p <= 1'b1;
      rc_q <= 1'b1; rc_p <= 1'b1;
      adr_q <= '0; dq_q <= '0;
      row_q <= '0; col_q <= '0;
      brst_q <= 1'b0;
    end else begin
      we_q <= we_n; we_p <= we_q;
      oe_q <= oe_n; oe_p <= oe_q;
      rc_q <= rc_n; rc_p <= rc_q;
      adr_q <= adr;
      dq_q <= dq_i;
      brst_q <= ~pin_rst_n;
      if (rc_p && !rc_q) row_q <= adr_q[ROW_W-1:0];
      if (!rc_p && rc_q) col_q <= adr_q;
    end
  end

  assign wr_stb   = !we_p && we_q;
  assign rd_stb   = oe_p && !oe_q;
  assign rd_act   = !oe_q;
  assign cur_addr = {row_q, col_q};
  assign wr_data  = dq_q;
  assign bus_rst  = brst_q;
endmodule

// File: rtl/flcs_cmd_decoder.sv
`timescale 1ns/1ps
module flcs_cmd_decoder
  import flcs_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst,
  input  logic              busy,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [7:0]        wr_data,
  output logic              go,
  output op_t               go_op,
  output logic [ADDR_W-1:0] go_addr,
  output logic [7:0]        go_data,
  output logic              seq_idle
);
  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_ADR_A);
  localparam logic [ADDR_W-1:0] KEY_B = ADDR_W'(KEY_ADR_B);

  seq_t st;
  logic hit_a, hit_b;
  assign hit_a = (cur_addr == KEY_A);
  assign hit_b = (cur_addr == KEY_B);
  assign seq_idle = (st == SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst || bus_rst) begin
      st <= SQ_IDLE; go <= 1'b0; go_op <= OP_PROG;
      go_addr <= '0; go_data <= '0;
    end else begin
      go <= 1'b0;
      if (wr_stb && !busy) begin
        st <= SQ_IDLE;
        case (st)
          SQ_IDLE: if (hit_a && wr_data == K_KEY_A) st <= SQ_UNL1;
          SQ_UNL1: if (hit_b && wr_data == K_KEY_B) st <= SQ_UNL2;
          SQ_UNL2: begin
            if (hit_a && wr_data == K_PROG)       st <= SQ_PGM;
            else if (hit_a && wr_data == K_ERASE) st <= SQ_ERS;
          end
          SQ_PGM: begin
            go <= 1'b1; go_op <= OP_PROG;
            go_addr <= cur_addr; go_data <= wr_data;
          end
          SQ_ERS:  if (hit_a && wr_data == K_KEY_A) st <= SQ_ERS1;
          SQ_ERS1: if (hit_b && wr_data == K_KEY_B) st <= SQ_ERS2;
          SQ_ERS2: begin
            go_addr <= cur_addr; go_data <= 8'hFF;
            if (wr_data == K_SECT) begin
              go <= 1'b1; go_op <= OP_SECT;
            end else if (wr_data == K_BLK) begin
              go <= 1'b1; go_op <= OP_BLK;
            end else if (wr_data == K_CHIP && hit_a) begin
              go <= 1'b1; go_op <= OP_CHIP;
            end
          end
          default: st <= SQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/flcs_op_engine.sv
`timescale 1ns/1ps
module flcs_op_engine
  import flcs_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int SECT_AW  = 6,
  parameter int BLK_AW   = 8,
  parameter int PROG_CYC = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst,
  input  logic              go,
  input  op_t               go_op,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [7:0]        go_data,
  input  logic              rd_stb,
  input  logic              rd_act,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              busy,
  output logic [7:0]        dq_o,
  output logic              dq_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SPAN  = (PROG_CYC > DEPTH) ? PROG_CYC : DEPTH;
  localparam int CNT_W = $clog2(SPAN + 1);
  localparam logic [ADDR_W-1:0] SECT_MSK = ADDR_W'((1 << SECT_AW) - 1);
  localparam logic [ADDR_W-1:0] BLK_MSK  = ADDR_W'((1 << BLK_AW) - 1);

  logic [7:0] mem [DEPTH];
  logic [7:0] rd_q, dat_q, dq_o_q, mem_wd;
  logic [ADDR_W-1:0] base_q, go_base, mem_wa, rd_addr;
  logic [CNT_W-1:0]  cnt_q, lim_q, go_lim;
  logic busy_q, tog_q, dq_oe_q, last, mem_we;
  op_t  op_q;

  always_comb begin
    case (go_op)
      OP_PROG: begin go_lim = CNT_W'(PROG_CYC - 1);       go_base = go_addr;              end
      OP_SECT: begin go_lim = CNT_W'((1 << SECT_AW) - 1); go_base = go_addr & ~SECT_MSK;  end
      OP_BLK:  begin go_lim = CNT_W'((1 << BLK_AW) - 1);  go_base = go_addr & ~BLK_MSK;   end
      default: begin go_lim = CNT_W'(DEPTH - 1);          go_base = '0;                   end
    endcase
  end

  assign last    = (cnt_q == lim_q);
  assign mem_we  = busy_q && ((op_q != OP_PROG) || last);
  assign mem_wa  = (op_q == OP_PROG) ? base_q : base_q + cnt_q[ADDR_W-1:0];
  assign mem_wd  = (op_q == OP_PROG) ? (rd_q & dat_q) : 8'hFF;
  assign rd_addr = busy_q ? base_q : cur_addr;

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= mem_wd;
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) dq_oe_q <= 1'b0;
    else     dq_oe_q <= rd_act;
  end

  always_ff @(posedge clk) begin
    if (rst || bus_rst) begin
      busy_q <= 1'b0; op_q <= OP_PROG; base_q <= '0;
      cnt_q <= '0; lim_q <= '0; dat_q <= '0;
      tog_q <= 1'b0; dq_o_q <= '0;
    end else begin
      if (go && !busy_q) begin
        busy_q <= 1'b1; op_q <= go_op; base_q <= go_base;
        lim_q <= go_lim; cnt_q <= '0; dat_q <= go_data; tog_q <= 1'b0;
      end else if (busy_q) begin
        if (last) busy_q <= 1'b0;
        else      cnt_q  <= cnt_q + 1'b1;
      end
      if (rd_stb) begin
        if (busy_q) begin
          dq_o_q <= {~dat_q[7], tog_q, 6'b0};
          tog_q  <= ~tog_q;
        end else begin
          dq_o_q <= rd_q;
        end
      end
    end
  end

  assign busy  = busy_q;
  assign dq_o  = dq_o_q;
  assign dq_oe = dq_oe_q;
endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
  import flcs_pkg::*;
#(
  parameter int ROW_W    = 4,
  parameter int COL_W    = 7,
  parameter int SECT_AW  = 6,
  parameter int BLK_AW   = 8,
  parameter int PROG_CYC = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_rst_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic             rc_n,
  input  logic [COL_W-1:0] adr,
  input  logic [7:0]       dq_i,
  output logic [7:0]       dq_o,
  output logic             dq_oe
);
  localparam int ADDR_W = ROW_W + COL_W;

  logic bus_rst, wr_stb, rd_stb, rd_act, busy, go, seq_idle;
  logic [ADDR_W-1:0] cur_addr, go_addr;
  logic [7:0] wr_data, go_data;
  op_t go_op;

  flcs_bus_sampler #(.ROW_W(ROW_W), .COL_W(COL_W)) u_smp (
    .clk(clk), .rst(rst), .pin_rst_n(pin_rst_n), .we_n(we_n), .oe_n(oe_n),
    .rc_n(rc_n), .adr(adr), .dq_i(dq_i), .bus_rst(bus_rst), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .rd_act(rd_act), .cur_addr(cur_addr), .wr_data(wr_data)
  );

  flcs_cmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .bus_rst(bus_rst), .busy(busy), .wr_stb(wr_stb),
    .cur_addr(cur_addr), .wr_data(wr_data), .go(go), .go_op(go_op),
    .go_addr(go_addr), .go_data(go_data), .seq_idle(seq_idle)
  );

  flcs_op_engine #(.ADDR_W(ADDR_W), .SECT_AW(SECT_AW), .BLK_AW(BLK_AW),
                   .PROG_CYC(PROG_CYC)) u_eng (
    .clk(clk), .rst(rst), .bus_rst(bus_rst), .go(go), .go_op(go_op),
    .go_addr(go_addr), .go_data(go_data), .rd_stb(rd_stb), .rd_act(rd_act),
    .cur_addr(cur_addr), .busy(busy), .dq_o(dq_o), .dq_oe(dq_oe)
  );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
`timescale 1ns/1ps
module flash_cmd_seq_chk
  import flcs_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int SECT_AW  = 6,
  parameter int BLK_AW   = 8,
  parameter int PROG_CYC = 200
) (
  input logic       clk,
  input logic       rst,
  input logic       oe_n,
  input logic       dq_oe,
  input logic [7:0] dq_o,
  input logic       busy,
  input logic       go,
  input op_t        go_op,
  input logic       bus_rst,
  input logic       rd_stb,
  input logic       seq_idle
);
  logic [1:0]  age;
  logic [31:0] bcnt;
  op_t         op_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      age <= '0; bcnt <= '0; op_l <= OP_PROG;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      bcnt <= busy ? bcnt + 32'd1 : 32'd0;
      if (go && !busy) op_l <= go_op;
    end
  end

  // R10
  oe_track_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (dq_oe == !$past(oe_n, 2)));

  // R8
  busy_lock_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !go);

  // R9
  status_low_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_stb) |=> (dq_o[5:0] == 6'd0));

  // R11
  pin_abort_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rst |=> (!busy && seq_idle));

  // R3
  prog_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(bus_rst) && op_l == OP_PROG) |-> (bcnt == PROG_CYC));

  // R4
  sect_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(bus_rst) && op_l == OP_SECT) |-> (bcnt == (1 << SECT_AW)));

  // R5
  blk_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(bus_rst) && op_l == OP_BLK) |-> (bcnt == (1 << BLK_AW)));

  // R6
  chip_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(bus_rst) && op_l == OP_CHIP) |-> (bcnt == (1 << ADDR_W)));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .ADDR_W(ROW_W + COL_W), .SECT_AW(SECT_AW), .BLK_AW(BLK_AW), .PROG_CYC(PROG_CYC)
) u_chk (
  .clk(clk), .rst(rst), .oe_n(oe_n), .dq_oe(dq_oe), .dq_o(dq_o), .busy(busy),
  .go(go), .go_op(go_op), .bus_rst(bus_rst), .rd_stb(rd_stb), .seq_idle(seq_idle)
);

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;
  localparam int ROW_W = 4, COL_W = 7, SECT_AW = 6, BLK_AW = 8, PROG_CYC = 200;
  localparam int DEPTH = 1 << (ROW_W + COL_W);
  localparam int KA = 'h5555 & (DEPTH - 1);
  localparam int KB = 'h2AAA & (DEPTH - 1);

  logic clk = 1'b0, rst = 1'b1, pin_rst_n = 1'b1;
  logic we_n = 1'b1, oe_n = 1'b1, rc_n = 1'b1;
  logic [COL_W-1:0] adr = '0;
  logic [7:0] dq_i = '0;
  logic [7:0] dq_o;
  logic dq_oe;

  always #4 clk = ~clk;

  flash_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .SECT_AW(SECT_AW),
                  .BLK_AW(BLK_AW), .PROG_CYC(PROG_CYC)) dut_i (
    .clk(clk), .rst(rst), .pin_rst_n(pin_rst_n), .we_n(we_n), .oe_n(oe_n),
    .rc_n(rc_n), .adr(adr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  typedef struct { string tag; logic [7:0] exp; } sb_item_t;
  sb_item_t sb[$];
  event smp_ev;
  logic [7:0] obs;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results and compares with the sampled bus
  initial begin
    forever begin
      @(smp_ev);
      if (sb.size() != 0) begin
        sb_item_t it;
        it = sb.pop_front();
        check(it.tag, obs, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_addr(input int a);
    adr = COL_W'(a >> COL_W); rc_n = 1'b0; tick(3);
    adr = COL_W'(a);          rc_n = 1'b1; tick(3);
  endtask

  task automatic bus_wr(input int a, input logic [7:0] d);
    bus_addr(a);
    dq_i = d; we_n = 1'b0; tick(3);
    we_n = 1'b1; tick(3);
  endtask

  task automatic cmd_prog(input int a, input logic [7:0] d);
    bus_wr(KA, 8'hAA); bus_wr(KB, 8'h55); bus_wr(KA, 8'hA0); bus_wr(a, d);
  endtask

  task automatic cmd_erase(input int a, input logic [7:0] c);
    bus_wr(KA, 8'hAA); bus_wr(KB, 8'h55); bus_wr(KA, 8'h80);
    bus_wr(KA, 8'hAA); bus_wr(KB, 8'h55); bus_wr(a, c);
  endtask

  // driver: pushes the expected byte, performs the read, hands the sample over
  task automatic rd(input int a, input logic [7:0] exp, input string tag);
    bus_addr(a); tick(3);
    sb.push_back('{tag, exp});
    oe_n = 1'b0; tick(4);
    obs = dq_o;
    check({tag, " oe R10"}, {7'd0, dq_oe}, 8'd1);
    -> smp_ev;
    #1;
    oe_n = 1'b1; tick(4);
  endtask

  task automatic pin_pulse();
    pin_rst_n = 1'b0; tick(3); pin_rst_n = 1'b1; tick(3);
  endtask

  initial begin
    tick(5); rst = 1'b0; tick(3);
    // R1: released bus after reset
    check("R1 dq_oe after reset", {7'd0, dq_oe}, 8'd0);
    check("R1 dq_o after reset", dq_o, 8'h00);

    // R6 / R9: chip erase with status polls
    cmd_erase(KA, 8'h10);
    rd(KA, 8'h00, "R9 erase poll first");
    rd(KA, 8'h40, "R9 erase poll toggled");
    tick(DEPTH + 40);
    rd(0, 8'hFF, "R6 chip erase low");
    rd(DEPTH - 1, 8'hFF, "R6 chip erase high");
    check("R10 released after read", {7'd0, dq_oe}, 8'd0);

    // R3 / R9 / R2: program with polls, row-only alias untouched
    cmd_prog('h123, 8'h5A);
    rd('h123, 8'h80, "R9 prog poll first");
    rd('h123, 8'hC0, "R9 prog poll toggled");
    tick(PROG_CYC + 20);
    rd('h123, 8'h5A, "R3 program data");
    rd('h0A3, 8'hFF, "R2 row half alias");
    cmd_prog('h123, 8'h0F); tick(PROG_CYC + 20);
    rd('h123, 8'h0A, "R3 program ANDs");

    // R8: erase sequence during a program is ignored
    cmd_prog('h200, 8'h33);
    cmd_erase(KA, 8'h10);
    tick(PROG_CYC + DEPTH + 40);
    rd('h200, 8'h33, "R8 busy ignore target");
    rd('h123, 8'h0A, "R8 busy ignore other");

    // R4: sector erase boundaries
    cmd_prog('h140, 8'h11); tick(PROG_CYC + 20);
    cmd_prog('h13F, 8'h22); tick(PROG_CYC + 20);
    cmd_erase('h123, 8'h30); tick((1 << SECT_AW) + 40);
    rd('h123, 8'hFF, "R4 sector inner");
    rd('h13F, 8'hFF, "R4 sector top");
    rd('h140, 8'h11, "R4 next sector kept");

    // R5: block erase boundaries
    cmd_prog('h2FF, 8'h44); tick(PROG_CYC + 20);
    cmd_prog('h300, 8'h55); tick(PROG_CYC + 20);
    cmd_erase('h250, 8'h50);
    rd('h250, 8'h00, "R9 block erase poll");
    tick((1 << BLK_AW) + 40);
    rd('h200, 8'hFF, "R5 block bottom");
    rd('h2FF, 8'hFF, "R5 block top");
    rd('h300, 8'h55, "R5 next block kept");

    // R7: broken sequences
    bus_wr(KA, 8'hAA); bus_wr('h111, 8'h55); bus_wr(KA, 8'hA0); bus_wr('h300, 8'h00);
    tick(PROG_CYC + 20);
    rd('h300, 8'h55, "R7 wrong unlock address");
    bus_wr(KA, 8'hAA); bus_wr(KB, 8'h55); bus_wr(KA, 8'h77);
    cmd_prog('h300, 8'h05); tick(PROG_CYC + 20);
    rd('h300, 8'h05, "R7 restart after bad command");

    // R6: chip erase off the unlock address does nothing
    cmd_erase('h100, 8'h10); tick(DEPTH + 40);
    rd('h300, 8'h05, "R6 chip erase needs 555h");

    // R11: pin reset aborts operation and sequence
    cmd_prog('h400, 8'h00); tick(5);
    pin_pulse();
    rd('h400, 8'hFF, "R11 read mode after abort");
    tick(PROG_CYC + 20);
    rd('h400, 8'hFF, "R11 aborted byte kept");
    bus_wr(KA, 8'hAA); bus_wr(KB, 8'h55);
    pin_pulse();
    bus_wr(KA, 8'hA0); bus_wr('h401, 8'h00); tick(PROG_CYC + 20);
    rd('h401, 8'hFF, "R11 sequence cancelled");

    tick(5);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule